// File: doc/BRIEF.md
# Three-Value Sequential Combination Lock

This block is a synchronous state machine that releases a door once a user has keyed in three values in the right order. The user places a 4-bit value on a data input and then pulses a strobe. The machine takes exactly one value per press, compares it with the entry the sequence expects next, and either moves one step forward or drops into a fault state. The three secret values are fixed at elaboration through parameters.

The strobe comes from a slow, asynchronous source such as a button. It passes through a synchroniser and a rising-edge detector, so a single press counts as one step no matter how long it is held. Both the fault state and the open state are terminal. Only the synchronous, active-high reset leaves them and returns the lock to its start state with the door shut. A parameter selects whether the state register is one-hot or binary. Either choice gives the same behaviour at the ports.

Top module: `combo_lock`

## Requirements
- R1: While rst is high on a clock edge, the lock goes to its start state: door_open and err read 0 after that edge and stay 0 until values are entered.
- R2: After three strobed values equal to CODE0, CODE1 and CODE2 in that order (defaults 4'h3, 4'hA, 4'h7), door_open is 1 and err is 0. The door output is registered and rises on the third clock edge after the third strobe's rising edge.
- R3: After one or two correct strobed values only, door_open and err are both 0.
- R4: A strobed value that differs from the entry expected at the current step sets err to 1 and keeps door_open at 0.
- R5: Once err is 1, it stays 1 and door_open stays 0 until reset, whatever values are strobed in, including correct ones.
- R6: Once door_open is 1, it stays 1 and err stays 0 until reset, whatever values are strobed in.
- R7: Changes on digit while new_in is low have no effect on the progress of the lock.
- R8: A press of new_in held high for many cycles advances the lock by exactly one step. The state register changes only in a cycle that follows a detected press.
- R9: door_open and err are never 1 at the same time.
- R10: The one-hot (ONE_HOT=1) and binary (ONE_HOT=0) state encodings give identical port behaviour. In one-hot mode exactly one state bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| new_in | input | 1 | Asynchronous strobe that marks a value as entered |
| digit | input | DW (4) | Value being entered |
| door_open | output | 1 | Registered door release, high only in the open state |
| err | output | 1 | Registered fault flag, high only in the fault state |

## Verification
The hardest case to reach is a wrong value at the third step. Getting there needs a reset and two correctly strobed values first. The bench therefore sweeps every 4-bit value at each of the three steps, and before each sweep point it rebuilds the prefix of correct entries from reset. Stickiness is tested by strobing the correct first entry again, after the lock has reached open or fault. Two further cases are checked: a strobe held for many cycles, and a digit bus that moves while no strobe is pressed. Both encodings run side by side on the same stimulus.

// File: rtl/lock_pkg.sv
package lock_pkg;

  localparam int ST_COUNT = 5;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_GOT1 = 3'd1,
    ST_GOT2 = 3'd2,
    ST_OPEN = 3'd3,
    ST_ERR  = 3'd4
  } lock_st_e;

  function automatic logic [ST_COUNT-1:0] st_encode(lock_st_e s, bit one_hot);
    logic [ST_COUNT-1:0] r;
    if (one_hot) r = ST_COUNT'(1) << s;
    else         r = ST_COUNT'(s);
    return r;
  endfunction

  function automatic lock_st_e st_decode(logic [ST_COUNT-1:0] v, bit one_hot);
    lock_st_e r;
    r = ST_IDLE;
    if (one_hot) begin
      for (int i = 0; i < ST_COUNT; i++)
        if (v[i]) r = lock_st_e'(3'(i));
    end else begin
      r = lock_st_e'(v[2:0]);
    end
    return r;
  endfunction

  function automatic lock_st_e st_next(lock_st_e cur, logic press, logic match);
    lock_st_e r;
    r = cur;
    if (press) begin
      case (cur)
        ST_IDLE: r = match ? ST_GOT1 : ST_ERR;
        ST_GOT1: r = match ? ST_GOT2 : ST_ERR;
        ST_GOT2: r = match ? ST_OPEN : ST_ERR;
        default: r = cur;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/lock_strobe_sync.sv
module lock_strobe_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_async,
  output logic press
);
  localparam int CHAIN = SYNC_STAGES + 1;

  logic [CHAIN-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[CHAIN-2:0], strobe_async};
  end

  assign press = chain_q[CHAIN-2] & ~chain_q[CHAIN-1];

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    press |=> !press);

endmodule

// File: rtl/lock_step_check.sv
module lock_step_check
  import lock_pkg::*;
#(
  parameter int DW = 4,
  parameter logic [DW-1:0] CODE0 = 4'h3,
  parameter logic [DW-1:0] CODE1 = 4'hA,
  parameter logic [DW-1:0] CODE2 = 4'h7
) (
  input  lock_st_e        cur,
  input  logic [DW-1:0]   digit,
  output logic            match
);
  function automatic logic [DW-1:0] expected_for(lock_st_e s);
    logic [DW-1:0] e;
    case (s)
      ST_IDLE: e = CODE0;
      ST_GOT1: e = CODE1;
      default: e = CODE2;
    endcase
    return e;
  endfunction

  assign match = (digit == expected_for(cur));

endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
  import lock_pkg::*;
#(
  parameter bit ONE_HOT = 1'b1
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     press,
  input  logic     match,
  output lock_st_e cur,
  output logic     door_q,
  output logic     err_q
);
  localparam int SW = ONE_HOT ? ST_COUNT : 3;

  logic [SW-1:0]       state_q;
  logic [ST_COUNT-1:0] nxt_code;
  lock_st_e            nxt;
  logic                at_got2;

  assign cur      = st_decode(ST_COUNT'(state_q), ONE_HOT);
  assign nxt      = st_next(cur, press, match);
  assign nxt_code = st_encode(nxt, ONE_HOT);
  assign at_got2  = (cur == ST_GOT2);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= nxt_code[SW-1:0] & '0 | st_encode(ST_IDLE, ONE_HOT)[SW-1:0];
      door_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= nxt_code[SW-1:0];
      door_q  <= (nxt == ST_OPEN);
      err_q   <= (nxt == ST_ERR);
    end
  end

  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q);
  assert_open_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    door_q |=> door_q);
  assert_door_err_excl_R9: assert property (@(posedge clk) disable iff (rst)
    !(door_q && err_q));
  assert_hold_without_press_R8: assert property (@(posedge clk) disable iff (rst)
    !press |=> $stable(state_q));
  assert_open_after_got2_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(door_q) |-> $past(at_got2 && press));

  generate
    if (ONE_HOT) begin : g_oh_check
      assert_onehot_state_R10: assert property (@(posedge clk) disable iff (rst)
        $countones(state_q) == 1);
    end
  endgenerate

endmodule

// File: rtl/combo_lock.sv
module combo_lock
  import lock_pkg::*;
#(
  parameter int DW = 4,
  parameter logic [DW-1:0] CODE0 = 4'h3,
  parameter logic [DW-1:0] CODE1 = 4'hA,
  parameter logic [DW-1:0] CODE2 = 4'h7,
  parameter bit ONE_HOT = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          new_in,
  input  logic [DW-1:0] digit,
  output logic          door_open,
  output logic          err
);
  logic     press;
  logic     match;
  lock_st_e cur;

  lock_strobe_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .strobe_async(new_in), .press(press)
  );

  lock_step_check #(.DW(DW), .CODE0(CODE0), .CODE1(CODE1), .CODE2(CODE2)) u_chk (
    .cur(cur), .digit(digit), .match(match)
  );

  lock_fsm #(.ONE_HOT(ONE_HOT)) u_fsm (
    .clk(clk), .rst(rst), .press(press), .match(match),
    .cur(cur), .door_q(door_open), .err_q(err)
  );

endmodule

// File: tb/tb_combo_lock.sv
module tb_combo_lock;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] K0 = 4'h3, K1 = 4'hA, K2 = 4'h7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic new_in = 1'b0;
  logic [3:0] digit = '0;
  logic door_a, err_a, door_b, err_b;
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  combo_lock #(.ONE_HOT(1'b1)) dut (
    .clk(clk), .rst(rst), .new_in(new_in), .digit(digit),
    .door_open(door_a), .err(err_a)
  );
  combo_lock #(.ONE_HOT(1'b0)) dut_bin (
    .clk(clk), .rst(rst), .new_in(new_in), .digit(digit),
    .door_open(door_b), .err(err_b)
  );

  function automatic logic [3:0] key_at(int step);
    return (step == 0) ? K0 : (step == 1) ? K1 : K2;
  endfunction

  task automatic check(string req, logic exp_door, logic exp_err);
    total++;
    if (door_a !== exp_door || err_a !== exp_err) begin
      bad++;
      $display("FAIL %s onehot: door=%b err=%b expected door=%b err=%b",
               req, door_a, err_a, exp_door, exp_err);
    end
    total++;
    if (door_b !== door_a || err_b !== err_a || door_b !== exp_door || err_b !== exp_err) begin
      bad++;
      $display("FAIL R10 (%s) binary: door=%b err=%b expected door=%b err=%b",
               req, door_b, err_b, exp_door, exp_err);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; new_in = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic strobe(logic [3:0] v, int hold);
    @(negedge clk); digit = v; new_in = 1'b1;
    repeat (hold) @(negedge clk);
    new_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    check("R1", 1'b0, 1'b0);

    // R2 R3 R4 R5 R6: sweep every value at each step
    for (int step = 0; step < 3; step++) begin
      for (int v = 0; v < 16; v++) begin
        logic good;
        do_reset();
        for (int k = 0; k < step; k++) strobe(key_at(k), 1);
        strobe(4'(v), 1);
        good = (4'(v) == key_at(step));
        if (!good) check("R4", 1'b0, 1'b1);
        else if (step == 2) check("R2", 1'b1, 1'b0);
        else check("R3", 1'b0, 1'b0);
        if (!good) begin
          strobe(K0, 1);
          check("R5", 1'b0, 1'b1);
        end else if (step == 2) begin
          strobe(K0, 1);
          check("R6", 1'b1, 1'b0);
        end
      end
    end

    // R7: bus moves with no strobe between entries
    do_reset();
    strobe(K0, 1);
    strobe(K1, 1);
    for (int v = 0; v < 16; v++) begin
      @(negedge clk); digit = 4'(v);
    end
    repeat (4) @(negedge clk);
    check("R7", 1'b0, 1'b0);
    strobe(K2, 1);
    check("R7", 1'b1, 1'b0);

    // R8: long hold of the first press counts once
    do_reset();
    strobe(K0, 25);
    check("R8", 1'b0, 1'b0);
    strobe(K1, 1);
    strobe(K2, 1);
    check("R8", 1'b1, 1'b0);

    // R1: reset from open state
    do_reset();
    @(negedge clk);
    check("R1", 1'b0, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule